// File: doc/BRIEF.md
# Serial GPIO Array Interrupt Controller

This block turns a two-dimensional array of serially captured inputs into interrupts. The signals form a grid of ports by bit positions, and signal number `bit + port * NBITS` arrives on the parallel sample bus at flat position `port * NBITS + bit`. Whenever the serial engine presents a fresh sample with a strobe, each signal is checked against its trigger mode and, for level mode, its polarity. Any event it finds is latched as pending.

Software reaches the block through a word-addressed register port with a combinational read. The control registers are arranged by bit index, and each word carries one bit per port. A pending signal counts as active when its enable bit is set. The block ORs every active signal together, gates the result with a master enable, and drives it onto one registered interrupt line.

Top module: `sio_irq_ctrl`

## Requirements
- R1: Every per-signal register word is selected by bit index. Within the word, bit p belongs to port p. The sample for (bit b, port p) is `smp_data[p*NBITS+b]`.
- R2: Address = block * MAXBITS + index. Blocks are: 0 config (index 0, bit 0 = master enable), 1 polarity, 2 trigger low bit, 3 trigger high bit, 4 acknowledge, 5 enable, 6 identity. The trigger high bank therefore sits MAXBITS words after the low bank. The 2-bit trigger code {high,low} means 0 level, 1 both edges, 2 falling, 3 rising.
- R3: In rising mode, a previous sample of 0 followed by a current sample of 1 sets pending.
- R4: In falling mode, a previous sample of 1 followed by a current sample of 0 sets pending.
- R5: In both-edges mode, any change between the previous and the current sample sets pending.
- R6: In level mode, each sample loads pending with `input XOR polarity`. Polarity 0 is active high and polarity 1 is active low. Polarity has no effect in the edge modes.
- R7: Writing a word to the acknowledge block clears the pending bits at its 1 positions and leaves the others unchanged. A level signal that is still active sets pending again on the next sample. An event detected in the same cycle as an acknowledge wins over the acknowledge.
- R8: Events latch even when the enable bit is 0. The identity word reads `pending AND enable`.
- R9: `irq` goes high one cycle after any identity bit is set while the master enable is 1. It is low whenever the master enable was 0 in the previous cycle.
- R10: After reset, every register, every pending bit and every stored previous sample is 0, and `irq` is 0.
- R11: Detection and the update of the previous sample happen only in cycles where `smp_valid` is high. Input changes without the strobe have no effect.
- R12: Writes to an index ≥ NBITS are ignored. Reads of such an index return 0, and reads of the acknowledge block return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Word address (block, index) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| smp_valid | input | 1 | New sample strobe from the serial engine |
| smp_data | input | NPORTS*NBITS | Deserialised input samples |
| irq | output | 1 | Combined, master-gated interrupt |

## Verification
The main sweep covers all four trigger codes and both polarities. Port p of every bit index is given the transition (p[0] → p[1]), so a single pass presents all four old/new pairs: 0→0, 1→0, 0→1 and 1→1. This separates rising, falling, both-edges and level detection, and shows whether polarity is applied. A single-bit stimulus confirms the bit/port placement. Directed sequences cover the remaining cases: acknowledge racing a sample, level re-assertion, masking versus latching, strobe-less input changes, and the master gate.

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl #(
  parameter int NPORTS  = 32,
  parameter int NBITS   = 4,
  parameter int MAXBITS = 32,
  localparam int IW = $clog2(MAXBITS),
  localparam int AW = IW + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [AW-1:0]           reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic                    smp_valid,
  input  logic [NPORTS*NBITS-1:0] smp_data,
  output logic                    irq
);
  localparam logic [2:0] B_CFG = 3'd0, B_POL = 3'd1, B_TLO = 3'd2,
                         B_THI = 3'd3, B_ACK = 3'd4, B_ENA = 3'd5, B_ID = 3'd6;

  logic [2:0]    blk;
  logic [IW-1:0] idx;
  logic          master_q, irq_q, any_id, ack_we;
  logic [NPORTS-1:0] pol_q [NBITS];
  logic [NPORTS-1:0] tlo_q [NBITS];
  logic [NPORTS-1:0] thi_q [NBITS];
  logic [NPORTS-1:0] ena_q [NBITS];
  logic [NPORTS-1:0] pend_q [NBITS];
  logic [NPORTS-1:0] prev_q [NBITS];
  logic [NPORTS-1:0] pend_d [NBITS];

  assign blk    = reg_addr[AW-1:IW];
  assign idx    = reg_addr[IW-1:0];
  assign ack_we = reg_we && blk == B_ACK;
  assign irq    = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      for (int b = 0; b < NBITS; b++) begin
        pol_q[b] <= '0;
        tlo_q[b] <= '0;
        thi_q[b] <= '0;
        ena_q[b] <= '0;
      end
    end else if (reg_we) begin
      if (blk == B_CFG && idx == '0) master_q <= reg_wdata[0];
      for (int b = 0; b < NBITS; b++) begin
        if (int'(idx) == b) begin
          case (blk)
            B_POL:   pol_q[b] <= reg_wdata[NPORTS-1:0];
            B_TLO:   tlo_q[b] <= reg_wdata[NPORTS-1:0];
            B_THI:   thi_q[b] <= reg_wdata[NPORTS-1:0];
            B_ENA:   ena_q[b] <= reg_wdata[NPORTS-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NBITS; b++) begin
      for (int p = 0; p < NPORTS; p++) begin
        logic cur, prv, hit, ack;
        cur = smp_data[p*NBITS+b];
        prv = prev_q[b][p];
        ack = ack_we && int'(idx) == b && reg_wdata[p];
        case ({thi_q[b][p], tlo_q[b][p]})
          2'd1:    hit = cur ^ prv;
          2'd2:    hit = prv & ~cur;
          2'd3:    hit = ~prv & cur;
          default: hit = cur ^ pol_q[b][p];
        endcase
        if (smp_valid) begin
          if ({thi_q[b][p], tlo_q[b][p]} == 2'd0) pend_d[b][p] = hit;
          else pend_d[b][p] = (pend_q[b][p] & ~ack) | hit;
        end else begin
          pend_d[b][p] = pend_q[b][p] & ~ack;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBITS; b++) begin
      if (!rst_n) begin
        pend_q[b] <= '0;
        prev_q[b] <= '0;
      end else begin
        pend_q[b] <= pend_d[b];
        if (smp_valid)
          for (int p = 0; p < NPORTS; p++) prev_q[b][p] <= smp_data[p*NBITS+b];
      end
    end
  end

  always_comb begin
    any_id = 1'b0;
    for (int b = 0; b < NBITS; b++) any_id = any_id | (|(pend_q[b] & ena_q[b]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= master_q & any_id;
  end

  always_comb begin
    reg_rdata = '0;
    if (blk == B_CFG && idx == '0) reg_rdata[0] = master_q;
    for (int b = 0; b < NBITS; b++) begin
      if (int'(idx) == b) begin
        case (blk)
          B_POL:   reg_rdata[NPORTS-1:0] = pol_q[b];
          B_TLO:   reg_rdata[NPORTS-1:0] = tlo_q[b];
          B_THI:   reg_rdata[NPORTS-1:0] = thi_q[b];
          B_ENA:   reg_rdata[NPORTS-1:0] = ena_q[b];
          B_ID:    reg_rdata[NPORTS-1:0] = pend_q[b] & ena_q[b];
          default: ;
        endcase
      end
    end
  end

  p_irq_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(master_q));

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(any_id));

  for (genvar g = 0; g < NBITS; g++) begin : g_chk
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && int'(idx) == g && !smp_valid)
      |=> ((pend_q[g] & $past(reg_wdata[NPORTS-1:0])) == '0));

    p_hold_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && !ack_we) |=> $stable(pend_q[g]));
  end
endmodule

// File: tb/sio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module sio_irq_ctrl_bench;
  localparam int NP = 4, NB = 3, MB = 8;
  localparam int A_CFG = 0, A_POL = 8, A_TLO = 16, A_THI = 24, A_ACK = 32, A_ENA = 40, A_ID = 48;

  logic clk = 0, rst_n = 0, we = 0, sv = 0, irq;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic [NP*NB-1:0] sd = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sio_irq_ctrl #(.NPORTS(NP), .NBITS(NB), .MAXBITS(MB)) u_sio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .smp_valid(sv), .smp_data(sd), .irq(irq));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = 6'(a); wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 6'(a); #1 d = rdata;
  endtask

  task automatic smp(input logic [NP*NB-1:0] v);
    @(negedge clk); sv = 1; sd = v;
    @(negedge clk); sv = 0;
  endtask

  task automatic set_all(input int base, input logic [31:0] d);
    for (int b = 0; b < NB; b++) wr(base + b, d);
  endtask

  function automatic logic [NP*NB-1:0] pat(input int sel);
    logic [NP*NB-1:0] v = '0;
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < NB; b++) v[p*NB+b] = sel ? p[1] : p[0];
    return v;
  endfunction

  function automatic bit ev(input int m, input int pol, input int pv, input int cu);
    case (m)
      0: return bit'(cu ^ pol);
      1: return pv != cu;
      2: return pv == 1 && cu == 0;
      default: return pv == 0 && cu == 1;
    endcase
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    rd(A_CFG, rv); chk("R10 cfg", rv, 0);
    for (int b = 0; b < NB; b++) begin
      rd(A_ENA + b, rv); chk("R10 ena", rv, 0);
      rd(A_TLO + b, rv); chk("R10 tlo", rv, 0);
      rd(A_ID + b, rv);  chk("R10 ident", rv, 0);
    end
    chk("R10 irq", {31'd0, irq}, 0);

    // R2 R3 R4 R5 R6 sweep over trigger code and polarity
    wr(A_CFG, 1);
    set_all(A_ENA, 32'hF);
    for (int m = 0; m < 4; m++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [31:0] e;
        set_all(A_TLO, m[0] ? 32'hF : 0);
        set_all(A_THI, m[1] ? 32'hF : 0);
        set_all(A_POL, pol ? 32'hF : 0);
        smp(pat(0));
        set_all(A_ACK, 32'hF);
        smp(pat(1));
        e = 0;
        for (int p = 0; p < NP; p++) e[p] = ev(m, pol, p & 1, (p >> 1) & 1);
        for (int b = 0; b < NB; b++) begin
          rd(A_ID + b, rv);
          chk(m == 0 ? "R6 level" : m == 1 ? "R5 both" : m == 2 ? "R4 fall" : "R3 rise", rv, e);
        end
        @(negedge clk);
        chk("R9 irq sweep", {31'd0, irq}, {31'd0, |e});
      end
    end

    // R1 placement: rising, single flat bit 1*NB+2
    set_all(A_TLO, 32'hF); set_all(A_THI, 32'hF);
    smp('0); set_all(A_ACK, 32'hF);
    smp(12'(1) << (1*NB+2));
    rd(A_ID + 2, rv); chk("R1 port bit", rv, 32'h2);
    rd(A_ID + 0, rv); chk("R1 other idx0", rv, 0);
    rd(A_ID + 1, rv); chk("R1 other idx1", rv, 0);

    // R7 acknowledge
    wr(A_ACK + 2, 32'h0); rd(A_ID + 2, rv); chk("R7 ack zero no effect", rv, 32'h2);
    wr(A_ACK + 2, 32'h2); rd(A_ID + 2, rv); chk("R7 ack clears", rv, 0);
    smp('0); set_all(A_ACK, 32'hF);
    @(negedge clk); sv = 1; sd = '1; we = 1; addr = 6'(A_ACK); wdata = 32'hF;
    @(negedge clk); sv = 0; we = 0;
    rd(A_ID, rv); chk("R7 event beats ack", rv, 32'hF);
    set_all(A_TLO, 0); set_all(A_THI, 0); set_all(A_POL, 0);
    smp('1);
    wr(A_ACK, 32'hF); rd(A_ID, rv); chk("R7 level ack", rv, 0);
    smp('1); rd(A_ID, rv); chk("R7 level reassert", rv, 32'hF);

    // R8 masking versus latching
    smp('0);
    set_all(A_ENA, 0);
    set_all(A_TLO, 32'hF); set_all(A_THI, 32'hF);
    smp('0); set_all(A_ACK, 32'hF);
    smp('1);
    rd(A_ID + 1, rv); chk("R8 masked ident", rv, 0);
    @(negedge clk); chk("R8 masked irq", {31'd0, irq}, 0);
    wr(A_ENA + 1, 32'hF);
    rd(A_ID + 1, rv); chk("R8 latched while masked", rv, 32'hF);
    rd(A_ID + 0, rv); chk("R8 still masked idx0", rv, 0);
    @(negedge clk); chk("R8 irq after enable", {31'd0, irq}, 1);

    // R9 master gate
    wr(A_CFG, 0); @(negedge clk); chk("R9 master off", {31'd0, irq}, 0);
    rd(A_CFG, rv); chk("R9 cfg readback", rv, 0);
    wr(A_CFG, 1); @(negedge clk); chk("R9 master on", {31'd0, irq}, 1);

    // R11 no strobe, no detection
    set_all(A_ENA, 32'hF);
    smp('0); set_all(A_ACK, 32'hF);
    @(negedge clk); sd = '1;
    repeat (4) @(negedge clk);
    rd(A_ID, rv); chk("R11 no strobe", rv, 0);
    smp('1); rd(A_ID, rv); chk("R11 prev kept on strobe", rv, 32'hF);

    // R12 and R2 bank layout
    wr(A_TLO + 3, 32'hF); rd(A_TLO + 3, rv); chk("R12 idx out of range", rv, 0);
    rd(A_ACK, rv); chk("R12 ack reads zero", rv, 0);
    wr(A_THI + 1, 32'h9);
    wr(A_TLO + 1, 32'h5);
    rd(A_TLO + 1, rv); chk("R2 low bank", rv, 32'h5);
    rd(A_THI + 1, rv); chk("R2 high bank offset", rv, 32'h9);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule